// File: doc/BRIEF.md
# Eight-Entry Bus Trace Store

This block is a small trace buffer that sits beside a processor's bus inside a debug unit. When its capture strobe fires and capture is enabled, it records one bus sample into an eight-slot circular store. A sample is a 20-bit address, a 16-bit data value and a 16-bit control word. Trace generation and the transport that carries register traffic to a host are outside the block.

Host software works through four 16-bit registers: control/status, write pointer, slice pointer and a data window. The control register sets one of three behaviours:
- trace that stops when the store is full;
- trace that keeps overwriting until a trigger freezes it;
- variable watch, which keeps only address and data.

Readout starts with a slice index. Each data-window read then returns the next 16-bit word of a stored entry, and the slice pointer advances on its own.

Top module: `trace_store`

## Requirements
- R1: After reset, the control/status, pointer and slice registers all read 0.
- R2: Writing control with bit 6 set clears the write position, the written, full and halted flags at that clock edge. Bit 6 always reads back 0. A capture in the same cycle as this reset is dropped.
- R3: Control register layout:
  - bit 0 enables capture;
  - bits [2:1] pick the mode (2'b10 variable watch, any other value trace);
  - bit 3 picks stop-when-full (1) or continuous (0);
  - status bit 8 is set after any capture, bit 9 when the store has filled, bit 10 when a trigger has halted capture;
  - all other bits read 0.
  The write position reads from bits [12:10] of the pointer register, and its other bits read 0.
- R4: In stop-when-full trace mode, the eighth capture sets the full flag and wraps the write position to 0. Later captures are ignored until a reset.
- R5: In continuous trace mode, captures overwrite the oldest slot in circular order, and the full flag sets on the first wrap. A trigger pulse then halts capture, so the last eight samples stay stored.
- R6: Captures have no effect while bit 0 is clear.
- R7: The slice pointer addresses one entry in bits [4:2]. In trace mode, successive data reads return four words per entry:
  - address bits [15:0];
  - address bits [19:16] in bits [3:0] of the word;
  - data;
  - control.
  The pointer then moves to the next entry, and entry 7 wraps to 0.
- R8: In variable-watch mode, captures are circular, the trigger is ignored, and each entry reads out as three words (address low, address high, data) before the pointer moves to the next entry.
- R9: A capture into the entry being read in the same cycle takes priority: the read returns the word of the newly captured sample.
- R10: Register select encoding is 0 control/status, 1 pointer, 2 slice, 3 data. A read strobe loads reg_rdata_o at the next edge, and the value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| capt_i | input | 1 | Capture strobe for the current bus sample |
| trig_i | input | 1 | Trigger pulse that halts continuous trace |
| smp_addr_i | input | 20 | Sampled bus address |
| smp_data_i | input | 16 | Sampled bus data |
| smp_ctrl_i | input | 16 | Sampled bus control word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |

## Verification
The in-line assertions check several rules on every cycle:
- the soft reset clears all pointer state by the next edge;
- the write position is frozen while the store is full, halted or disabled;
- filling the last slot raises the full flag;
- the slice pointer steps by one word in trace mode and jumps to the next entry after the third word in watch mode.

Some behaviour only the bench scenarios can show:
- the stored contents and word order seen through the data window;
- continuous mode keeping the newest eight samples across a wrap;
- the capture-over-read bypass;
- the reset dropping a same-cycle capture;
- the exact register bit layouts.

// File: rtl/trace_store_pkg.sv
package trace_store_pkg;
  localparam int ADDR_W_D = 20;
  localparam int WORD_W_D = 16;
  localparam int DEPTH_D  = 8;

  // control/status bit positions
  localparam int CB_EN   = 0;
  localparam int CB_MODE = 1;
  localparam int CB_UF   = 3;
  localparam int CB_RST  = 6;
  localparam int SB_WR   = 8;
  localparam int SB_FULL = 9;
  localparam int SB_HALT = 10;
  localparam int PTR_LSB = 10;

  localparam logic [1:0] MODE_WATCH = 2'b10;

  typedef enum logic [1:0] {
    RS_CTRL  = 2'd0,
    RS_PTR   = 2'd1,
    RS_SLICE = 2'd2,
    RS_DATA  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/trace_ctl.sv
module trace_ctl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [3:0]    cfg_wdata_i,
  input  logic          rst_req_i,
  input  logic          capt_i,
  input  logic          trig_i,
  output logic          en_o,
  output logic [1:0]    mode_o,
  output logic          uf_o,
  output logic          watch_o,
  output logic [PW-1:0] wp_o,
  output logic          written_o,
  output logic          full_o,
  output logic          halted_o,
  output logic          we_o
);
  import trace_store_pkg::*;

  assign watch_o = (mode_o == MODE_WATCH);

  // stop-when-full only applies to trace modes; watch is always circular
  logic blocked;
  assign blocked = halted_o | (uf_o & ~watch_o & full_o);
  assign we_o    = capt_i & en_o & ~rst_req_i & ~blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      mode_o    <= '0;
      uf_o      <= 1'b0;
      wp_o      <= '0;
      written_o <= 1'b0;
      full_o    <= 1'b0;
      halted_o  <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        en_o   <= cfg_wdata_i[CB_EN];
        mode_o <= cfg_wdata_i[CB_MODE +: 2];
        uf_o   <= cfg_wdata_i[CB_UF];
      end
      if (rst_req_i) begin
        wp_o      <= '0;
        written_o <= 1'b0;
        full_o    <= 1'b0;
        halted_o  <= 1'b0;
      end else begin
        if (we_o) begin
          wp_o      <= wp_o + 1'b1;  // DEPTH is a power of two
          written_o <= 1'b1;
          if (wp_o == PW'(DEPTH - 1)) full_o <= 1'b1;
        end
        if (trig_i && en_o && !watch_o && !uf_o) halted_o <= 1'b1;
      end
    end
  end

  a_r2_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (wp_o == '0 && !written_o && !full_o && !halted_o));
  a_r4_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && uf_o && !watch_o && !rst_req_i && !cfg_we_i) |=> $stable(wp_o));
  a_r4_last_slot_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && wp_o == PW'(DEPTH - 1)) |=> full_o);
  a_r5_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !rst_req_i) |=> $stable(wp_o));
  a_r6_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !rst_req_i) |=> $stable(wp_o));
endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PW-1:0]     wr_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] ctrl_i,
  input  logic [PW-1:0]     rd_idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] ctrl_o
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [WORD_W-1:0] data_q [DEPTH];
  logic [WORD_W-1:0] ctrl_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && wr_idx_i == PW'(g)) begin
        addr_q[g] <= addr_i;
        data_q[g] <= data_i;
        ctrl_q[g] <= ctrl_i;
      end
    end
  end

  // capture wins over a read of the same slot
  logic hit;
  assign hit    = we_i && (wr_idx_i == rd_idx_i);
  assign addr_o = hit ? addr_i : addr_q[rd_idx_i];
  assign data_o = hit ? data_i : data_q[rd_idx_i];
  assign ctrl_o = hit ? ctrl_i : ctrl_q[rd_idx_i];
endmodule

// File: rtl/trace_rd.sv
module trace_rd #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int SW = PW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slice_we_i,
  input  logic [SW-1:0]     slice_wdata_i,
  input  logic              data_rd_i,
  input  logic              watch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] ctrl_i,
  output logic [PW-1:0]     rd_idx_o,
  output logic [SW-1:0]     slice_o,
  output logic [WORD_W-1:0] word_o
);
  logic [SW-1:0] slice_q;
  logic [1:0]    wsel;

  assign slice_o  = slice_q;
  assign rd_idx_o = slice_q[SW-1:2];
  assign wsel     = slice_q[1:0];

  always_comb begin
    unique case (wsel)
      2'd0:    word_o = addr_i[WORD_W-1:0];
      2'd1:    word_o = {{(2*WORD_W-ADDR_W){1'b0}}, addr_i[ADDR_W-1:WORD_W]};
      2'd2:    word_o = data_i;
      default: word_o = ctrl_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              slice_q <= '0;
    else if (slice_we_i)      slice_q <= slice_wdata_i;
    else if (data_rd_i) begin
      if (watch_i && wsel == 2'd2) slice_q <= {rd_idx_o + 1'b1, 2'b00};
      else                         slice_q <= slice_q + 1'b1;
    end
  end

  a_r7_trace_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!watch_i && data_rd_i && !slice_we_i) |=> (slice_q == SW'($past(slice_q) + 1'b1)));
  a_r8_watch_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (watch_i && data_rd_i && !slice_we_i && wsel == 2'd2) |=> (slice_q[1:0] == 2'd0));
endmodule

// File: rtl/trace_store.sv
module trace_store
  import trace_store_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_D,
  parameter int WORD_W = WORD_W_D,
  parameter int DEPTH  = DEPTH_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capt_i,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] smp_addr_i,
  input  logic [WORD_W-1:0] smp_data_i,
  input  logic [WORD_W-1:0] smp_ctrl_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int SW = PW + 2;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel_i);

  logic cfg_we, rst_req, slice_we, data_rd;
  assign cfg_we   = reg_wr_i && sel == RS_CTRL;
  assign rst_req  = cfg_we && reg_wdata_i[CB_RST];
  assign slice_we = reg_wr_i && sel == RS_SLICE;
  assign data_rd  = reg_rd_i && sel == RS_DATA;

  logic          en, uf, watch, written, full, halted, we;
  logic [1:0]    mode;
  logic [PW-1:0] wp, rd_idx;
  logic [SW-1:0] slice;
  logic [ADDR_W-1:0] m_addr;
  logic [WORD_W-1:0] m_data, m_ctrl, word;

  trace_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk_i, .rst_ni, .cfg_we_i(cfg_we), .cfg_wdata_i(reg_wdata_i[3:0]),
    .rst_req_i(rst_req), .capt_i, .trig_i, .en_o(en), .mode_o(mode),
    .uf_o(uf), .watch_o(watch), .wp_o(wp), .written_o(written),
    .full_o(full), .halted_o(halted), .we_o(we)
  );

  trace_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk_i, .we_i(we), .wr_idx_i(wp), .addr_i(smp_addr_i), .data_i(smp_data_i),
    .ctrl_i(smp_ctrl_i), .rd_idx_i(rd_idx), .addr_o(m_addr), .data_o(m_data),
    .ctrl_o(m_ctrl)
  );

  trace_rd #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_rd (
    .clk_i, .rst_ni, .slice_we_i(slice_we), .slice_wdata_i(reg_wdata_i[SW-1:0]),
    .data_rd_i(data_rd), .watch_i(watch), .addr_i(m_addr), .data_i(m_data),
    .ctrl_i(m_ctrl), .rd_idx_o(rd_idx), .slice_o(slice), .word_o(word)
  );

  logic [WORD_W-1:0] stat_w, ptr_w, rd_mux;
  always_comb begin
    stat_w              = '0;
    stat_w[CB_EN]       = en;
    stat_w[CB_MODE +: 2] = mode;
    stat_w[CB_UF]       = uf;
    stat_w[SB_WR]       = written;
    stat_w[SB_FULL]     = full;
    stat_w[SB_HALT]     = halted;
    ptr_w               = '0;
    ptr_w[PTR_LSB +: PW] = wp;
    unique case (sel)
      RS_CTRL:  rd_mux = stat_w;
      RS_PTR:   rd_mux = ptr_w;
      RS_SLICE: rd_mux = WORD_W'(slice);
      default:  rd_mux = word;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end

  a_r10_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

// File: tb/trace_store_tb_top.sv
module trace_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        capt = 1'b0, trig = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [19:0] s_addr = '0;
  logic [15:0] s_data = '0, s_ctrl = '0, wdata = '0;
  logic [1:0]  sel = '0;
  logic [15:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_store dut_i (
    .clk_i(clk), .rst_ni(rst_n), .capt_i(capt), .trig_i(trig),
    .smp_addr_i(s_addr), .smp_data_i(s_data), .smp_ctrl_i(s_ctrl),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  function automatic logic [19:0] a_of(int id);
    return {4'((id % 15) + 1), 16'(16'h1000 + id)};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_smp(int id);
    s_addr = a_of(id);
    s_data = 16'(16'hD000 + id);
    s_ctrl = 16'(16'hC000 + id);
  endtask

  task automatic wreg(logic [1:0] s, logic [15:0] d);
    @(negedge clk); wr = 1'b1; sel = s; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] s, string req, logic [15:0] exp);
    @(negedge clk); rd = 1'b1; sel = s;
    @(negedge clk); rd = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic cap(int id);
    @(negedge clk); capt = 1'b1; set_smp(id);
    @(negedge clk); capt = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  // {kind, sel, value, expected, req}; kind 0 write, 1 read-check, 2 capture
  localparam int NV = 33;
  localparam logic [39:0] VEC [NV] = '{
    {2'd1, 2'd0, 16'h0000, 16'h0000, 4'd1},  // R1 control
    {2'd1, 2'd1, 16'h0000, 16'h0000, 4'd1},  // R1 pointer
    {2'd0, 2'd0, 16'h0009, 16'h0000, 4'd0},  // stop-when-full trace, enabled
    {2'd2, 2'd0, 16'd0,    16'h0000, 4'd0},
    {2'd2, 2'd0, 16'd1,    16'h0000, 4'd0},
    {2'd2, 2'd0, 16'd2,    16'h0000, 4'd0},
    {2'd1, 2'd1, 16'h0000, 16'h0C00, 4'd3},  // R3 pointer at [12:10]
    {2'd1, 2'd0, 16'h0000, 16'h0109, 4'd3},  // R3 written flag
    {2'd2, 2'd0, 16'd3,    16'h0000, 4'd0},
    {2'd2, 2'd0, 16'd4,    16'h0000, 4'd0},
    {2'd2, 2'd0, 16'd5,    16'h0000, 4'd0},
    {2'd2, 2'd0, 16'd6,    16'h0000, 4'd0},
    {2'd2, 2'd0, 16'd7,    16'h0000, 4'd0},
    {2'd1, 2'd0, 16'h0000, 16'h0309, 4'd4},  // R4 full
    {2'd1, 2'd1, 16'h0000, 16'h0000, 4'd4},  // R4 wrapped
    {2'd2, 2'd0, 16'd50,   16'h0000, 4'd0},  // ignored
    {2'd1, 2'd1, 16'h0000, 16'h0000, 4'd4},
    {2'd0, 2'd2, 16'h0000, 16'h0000, 4'd0},  // slice -> entry 0
    {2'd1, 2'd3, 16'h0000, 16'h1000, 4'd4},  // R4 entry 0 intact
    {2'd1, 2'd3, 16'h0000, 16'h0001, 4'd7},  // R7 addr high
    {2'd1, 2'd3, 16'h0000, 16'hD000, 4'd7},
    {2'd1, 2'd3, 16'h0000, 16'hC000, 4'd7},
    {2'd1, 2'd3, 16'h0000, 16'h1001, 4'd7},  // R7 next entry
    {2'd1, 2'd2, 16'h0000, 16'h0005, 4'd10}, // R10 slice readback
    {2'd0, 2'd2, 16'd28,   16'h0000, 4'd0},  // slice -> entry 7
    {2'd1, 2'd3, 16'h0000, 16'h1007, 4'd7},
    {2'd1, 2'd3, 16'h0000, 16'h0008, 4'd7},
    {2'd1, 2'd3, 16'h0000, 16'hD007, 4'd7},
    {2'd1, 2'd3, 16'h0000, 16'hC007, 4'd7},
    {2'd1, 2'd3, 16'h0000, 16'h1000, 4'd7},  // R7 wrap 7 -> 0
    {2'd0, 2'd0, 16'h0049, 16'h0000, 4'd0},  // soft reset
    {2'd1, 2'd0, 16'h0000, 16'h0009, 4'd2},  // R2 flags cleared, bit 6 reads 0
    {2'd1, 2'd1, 16'h0000, 16'h0000, 4'd2}   // R2
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rreg(2'd2, "R1", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      case (v[39:38])
        2'd0: wreg(v[37:36], v[35:20]);
        2'd1: rreg(v[37:36], $sformatf("R%0d", v[3:0]), v[19:4]);
        default: cap(int'(v[35:20]));
      endcase
    end

    // R5 continuous trace: ids 10..19, oldest is 12 at slot 2
    wreg(2'd0, 16'h0041);
    for (int k = 10; k < 20; k++) cap(k);
    rreg(2'd1, "R5", 16'h0800);
    rreg(2'd0, "R5", 16'h0301);
    wreg(2'd2, 16'd8);
    rreg(2'd3, "R5", 16'h100C);
    wreg(2'd2, 16'd0);
    rreg(2'd3, "R5", 16'h1012);
    pulse_trig();
    cap(20);
    rreg(2'd1, "R5", 16'h0800);
    rreg(2'd0, "R5", 16'h0701);
    wreg(2'd2, 16'd8);
    rreg(2'd3, "R5", 16'h100C);

    // R6 disabled
    wreg(2'd0, 16'h0040);
    cap(21);
    rreg(2'd1, "R6", 16'h0000);
    rreg(2'd0, "R6", 16'h0000);

    // R8 watch mode: trigger ignored, three words per entry
    wreg(2'd0, 16'h0045);
    cap(30); cap(31);
    pulse_trig();
    cap(32);
    rreg(2'd1, "R8", 16'h0C00);
    rreg(2'd0, "R8", 16'h0105);
    wreg(2'd2, 16'd0);
    rreg(2'd3, "R8", 16'h101E);
    rreg(2'd3, "R8", 16'h0001);
    rreg(2'd3, "R8", 16'hD01E);
    rreg(2'd3, "R8", 16'h101F);

    // R9 capture and read of slot 3 together
    wreg(2'd2, 16'd12);
    @(negedge clk); capt = 1'b1; set_smp(40); rd = 1'b1; sel = 2'd3;
    @(negedge clk); capt = 1'b0; rd = 1'b0;
    chk("R9", rdata, 16'h1028);
    rreg(2'd3, "R9", 16'h000B);

    // R10 read data holds without a strobe
    repeat (3) @(negedge clk);
    chk("R10", rdata, 16'h000B);

    // R2 reset drops a same-cycle capture
    @(negedge clk); wr = 1'b1; sel = 2'd0; wdata = 16'h0045; capt = 1'b1; set_smp(41);
    @(negedge clk); wr = 1'b0; capt = 1'b0;
    rreg(2'd1, "R2", 16'h0000);
    rreg(2'd0, "R2", 16'h0005);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule